// File: doc/BRIEF.md
# Mesh Tile Router with Per-Color Multicast

This block is the switch in one tile of a two-dimensional processor mesh. It has five ports: four to the neighbouring tiles (north, south, east, west) and one to the tile's own core. Every port can take in one word and send out one word in every cycle, and all five ports work at once. Each word carries a small virtual-channel tag, called its color.

Routing needs no address. A table, written ahead of time and rewritable while traffic runs, gives one output bitmask for each pair of input port and color. When a word arrives, the router looks up its mask and stores the word with that mask in the queue of the input port. The word is then copied to every output whose bit is set. A word with several destinations waits at the head of its queue until every chosen output has taken a copy. An output that already has its copy is not offered the word again. Where several inputs want the same output, a round-robin arbiter for that output chooses one each cycle.

A word taken in at a clock edge can leave on an idle, ready output in the next cycle, so a hop costs one cycle.

Top module: `mesh_router`

## Requirements
- R1: After reset, no output is valid, every input reports ready, and every table entry holds the empty mask, so a word that arrives before any table write is dropped and reaches no output.
- R2: A word taken on input port p with color c is sent to exactly the outputs whose bits are set in the table entry for (p, c), with its data and color unchanged. Port index and mask bit use one order: 0 north, 1 south, 2 east, 3 west, 4 core.
- R3: A multicast word is sent exactly once on each selected output, even when the outputs take it in different cycles.
- R4: A word taken in at a clock edge is valid on a free, ready selected output in the cycle that follows that edge.
- R5: While a selected output holds its ready low, the word stays valid there and stays at the head of its input queue. Outputs that have already taken it show no further copy.
- R6: An input reports not ready exactly when its queue holds QDEPTH words. No word offered while not ready is taken.
- R7: When several queue heads want the same output, the output grants them in rotation, so two inputs that both have words waiting alternate.
- R8: A table write changes one (port, color) entry at the clock edge. Words taken at that same edge still use the old entry, and words taken from the next edge on use the new one. A write that names a port index of 5 or above changes nothing.
- R9: A word whose mask is empty leaves its queue without reaching any output, so a stream of such words never makes the input report not ready.
- R10: Five words on the five inputs that target five different outputs all leave in the same cycle.
- R11: Words from one input to one output leave in the order they were taken in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 5 | Per-port incoming word present |
| rx_color | input | 5 x COLOR_W | Per-port virtual-channel color of the incoming word |
| rx_data | input | 5 x DATA_W | Per-port incoming word |
| rx_ready | output | 5 | Per-port queue has room |
| tx_valid | output | 5 | Per-port outgoing word present |
| tx_color | output | 5 x COLOR_W | Color of the outgoing word |
| tx_data | output | 5 x DATA_W | Outgoing word |
| tx_ready | input | 5 | Per-port downstream accepts the word |
| cfg_we | input | 1 | Table write strobe |
| cfg_port | input | 3 | Input port index of the entry to write |
| cfg_color | input | COLOR_W | Color of the entry to write |
| cfg_mask | input | 5 | New output mask for the entry |

## Verification
A corrupted delivered-copy mask shows up at the ports in the cycle after a stalled output releases. Either a second copy of the same word appears on an output that already took it, or the queue pops too early and the stalled output never gets the word. A stuck arbiter pointer shows as the same source winning the core port twice in a row while the other source waits. A table that loads late shows as a word sent by the old entry one cycle too long. Each output word is tagged with its source, so any loss, duplicate or reordering is found on the very word it affects.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;

    localparam int NPORT      = 5;
    localparam int PORT_IDX_W = 3;

    localparam int P_NORTH = 0;
    localparam int P_SOUTH = 1;
    localparam int P_EAST  = 2;
    localparam int P_WEST  = 3;
    localparam int P_CORE  = 4;

    typedef logic [NPORT-1:0] port_mask_t;

endpackage

// File: rtl/mr_queue.sv
module mr_queue #(
    parameter int W     = 24,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         ready,
    output logic         head_valid,
    output logic [W-1:0] head_data
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct {
        logic [W-1:0]    mem [DEPTH];
        logic [PW-1:0]   rd;
        logic [PW-1:0]   wr;
        logic [CNTW-1:0] cnt;
    } q_state_t;

    q_state_t q_d, q_q;
    logic     do_push;
    logic     do_pop;

    assign ready      = (q_q.cnt != CNTW'(DEPTH));
    assign head_valid = (q_q.cnt != '0);
    assign head_data  = q_q.mem[q_q.rd];

    always_comb begin
        q_d     = q_q;
        do_push = push && ready;
        do_pop  = pop && head_valid;
        if (do_push) begin
            q_d.mem[q_q.wr] = push_data;
            q_d.wr = (q_q.wr == PW'(DEPTH - 1)) ? '0 : q_q.wr + 1'b1;
        end
        if (do_pop) begin
            q_d.rd = (q_q.rd == PW'(DEPTH - 1)) ? '0 : q_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) q_q.mem[i] <= '0;
            q_q.rd  <= '0;
            q_q.wr  <= '0;
            q_q.cnt <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.cnt == CNTW'(DEPTH)) |=> (q_q.cnt <= CNTW'(DEPTH)));  // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.cnt == '0) |=> (q_q.cnt <= CNTW'(1)));  // R6

endmodule

// File: rtl/mr_rr_arb.sv
module mr_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         advance,
    output logic [N-1:0] grant
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic          found;
    logic [PW-1:0] pick;
    int            j;

    always_comb begin
        st_d  = st_q;
        grant = '0;
        found = 1'b0;
        pick  = st_q.ptr;
        j     = 0;
        for (int i = 0; i < N; i++) begin
            j = int'(st_q.ptr) + i;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                found    = 1'b1;
                grant[j] = 1'b1;
                pick     = PW'(j);
            end
        end
        if (found && advance) begin
            st_d.ptr = (pick == PW'(N - 1)) ? '0 : pick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));  // R7
    AST_GRANT_IF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> ((grant & req) == grant) && (|grant));  // R7
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(st_q.ptr) < N));  // R7

endmodule

// File: rtl/mr_route_table.sv
module mr_route_table
    import mesh_router_pkg::*;
#(
    parameter int COLOR_W = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [PORT_IDX_W-1:0]               wr_port,
    input  logic [COLOR_W-1:0]                  wr_color,
    input  port_mask_t                          wr_mask,
    input  logic [NPORT-1:0][COLOR_W-1:0]       rd_color,
    output logic [NPORT-1:0][NPORT-1:0]         rd_mask
);
    localparam int NCOLOR = 1 << COLOR_W;
    localparam int NENT   = NPORT * NCOLOR;
    localparam int IW     = $clog2(NENT);

    typedef struct {
        port_mask_t ent [NENT];
    } tab_state_t;

    tab_state_t    st_d, st_q;
    logic [IW-1:0] wr_idx;
    logic          wr_ok;

    always_comb begin
        st_d   = st_q;
        wr_ok  = we && (int'(wr_port) < NPORT);
        wr_idx = IW'(int'(wr_port) * NCOLOR + int'(wr_color));
        if (wr_ok) st_d.ent[wr_idx] = wr_mask;
        for (int p = 0; p < NPORT; p++) begin
            rd_mask[p] = st_q.ent[IW'(p * NCOLOR + int'(rd_color[p]))];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) st_q.ent[i] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (st_q.ent[$past(wr_idx)] == $past(wr_mask)));  // R8

endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import mesh_router_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COLOR_W = 3,
    parameter int QDEPTH  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0]              rx_valid,
    input  logic [NPORT-1:0][COLOR_W-1:0] rx_color,
    input  logic [NPORT-1:0][DATA_W-1:0]  rx_data,
    output logic [NPORT-1:0]              rx_ready,
    output logic [NPORT-1:0]              tx_valid,
    output logic [NPORT-1:0][COLOR_W-1:0] tx_color,
    output logic [NPORT-1:0][DATA_W-1:0]  tx_data,
    input  logic [NPORT-1:0]              tx_ready,
    input  logic                          cfg_we,
    input  logic [PORT_IDX_W-1:0]         cfg_port,
    input  logic [COLOR_W-1:0]            cfg_color,
    input  logic [NPORT-1:0]              cfg_mask
);
    localparam int ENTRY_W = NPORT + COLOR_W + DATA_W;

    typedef struct packed {
        port_mask_t          mask;
        logic [COLOR_W-1:0]  color;
        logic [DATA_W-1:0]   data;
    } entry_t;

    typedef struct packed {
        logic [NPORT-1:0][NPORT-1:0] sent;
    } rt_state_t;

    rt_state_t                    st_d, st_q;
    logic [NPORT-1:0][NPORT-1:0]  route_mask;
    logic [NPORT-1:0][ENTRY_W-1:0] q_in;
    logic [NPORT-1:0][ENTRY_W-1:0] q_head;
    logic [NPORT-1:0]             head_valid;
    entry_t                       head [NPORT];
    logic [NPORT-1:0][NPORT-1:0]  rem;
    logic [NPORT-1:0][NPORT-1:0]  req;
    logic [NPORT-1:0][NPORT-1:0]  grant;
    logic [NPORT-1:0][NPORT-1:0]  done;
    logic [NPORT-1:0]             pop;

    mr_route_table #(.COLOR_W(COLOR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wr_port  (cfg_port),
        .wr_color (cfg_color),
        .wr_mask  (cfg_mask),
        .rd_color (rx_color),
        .rd_mask  (route_mask)
    );

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            q_in[p] = {route_mask[p], rx_color[p], rx_data[p]};
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_inq
        mr_queue #(.W(ENTRY_W), .DEPTH(QDEPTH)) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (rx_valid[p]),
            .push_data  (q_in[p]),
            .pop        (pop[p]),
            .ready      (rx_ready[p]),
            .head_valid (head_valid[p]),
            .head_data  (q_head[p])
        );
    end

    // Outstanding outputs of each head, transposed into per-output requests.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            head[p] = entry_t'(q_head[p]);
            rem[p]  = head_valid[p] ? (head[p].mask & ~st_q.sent[p]) : '0;
        end
        for (int o = 0; o < NPORT; o++) begin
            for (int p = 0; p < NPORT; p++) begin
                req[o][p] = rem[p][o];
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_arb
        mr_rr_arb #(.N(NPORT)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req[o]),
            .advance (tx_ready[o]),
            .grant   (grant[o])
        );
    end

    // Output muxing, delivery tracking and queue release.
    always_comb begin
        st_d = st_q;
        for (int o = 0; o < NPORT; o++) begin
            tx_valid[o] = |req[o];
            tx_data[o]  = '0;
            tx_color[o] = '0;
            for (int p = 0; p < NPORT; p++) begin
                if (grant[o][p]) begin
                    tx_data[o]  = head[p].data;
                    tx_color[o] = head[p].color;
                end
            end
        end
        for (int p = 0; p < NPORT; p++) begin
            for (int o = 0; o < NPORT; o++) begin
                done[p][o] = grant[o][p] & tx_ready[o];
            end
            pop[p] = head_valid[p] && ((rem[p] & ~done[p]) == '0);
            st_d.sent[p] = pop[p] ? '0 : (st_q.sent[p] | done[p]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_chk_in
        AST_SENT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            head_valid[p] |-> ((st_q.sent[p] & ~head[p].mask) == '0));  // R3
        AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (head_valid[p] && !pop[p]) |=> (head_valid[p] && $stable(q_head[p])));  // R5
        for (genvar o = 0; o < NPORT; o++) begin : g_chk_pair
            AST_NO_DUP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
                done[p][o] |-> !st_q.sent[p][o]);  // R3
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_chk_out
        AST_TX_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid[o] |-> $onehot(grant[o]));  // R2
    end

endmodule

// File: tb/mesh_router_test.sv
module mesh_router_test;
    localparam int NP  = 5;
    localparam int DW  = 16;
    localparam int CW  = 3;
    localparam int QD  = 4;
    localparam int SBD = 64;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NP-1:0]          rx_valid = '0;
    logic [NP-1:0][CW-1:0]  rx_color = '0;
    logic [NP-1:0][DW-1:0]  rx_data = '0;
    logic [NP-1:0]          rx_ready;
    logic [NP-1:0]          tx_valid;
    logic [NP-1:0][CW-1:0]  tx_color;
    logic [NP-1:0][DW-1:0]  tx_data;
    logic [NP-1:0]          tx_ready = '1;
    logic                   cfg_we = 1'b0;
    logic [2:0]             cfg_port = '0;
    logic [CW-1:0]          cfg_color = '0;
    logic [NP-1:0]          cfg_mask = '0;

    int checks = 0;
    int errors = 0;
    int seq = 0;
    bit finished = 1'b0;

    logic [NP-1:0]    mtab [NP][8];
    logic [CW+DW-1:0] sb [NP][NP][SBD];
    int               sb_wr [NP][NP];
    int               sb_rd [NP][NP];
    bit               log_on = 1'b0;
    int               log_src [32];
    int               log_n = 0;

    mesh_router #(.DATA_W(DW), .COLOR_W(CW), .QDEPTH(QD)) uut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_color(rx_color), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_color(tx_color), .tx_data(tx_data), .tx_ready(tx_ready),
        .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_color(cfg_color), .cfg_mask(cfg_mask)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk_word(input int src);
        logic [DW-1:0] w;
        w = {3'(src), 13'(seq)};
        seq++;
        return w;
    endfunction

    function automatic int pending_to(input int o);
        int n = 0;
        for (int p = 0; p < NP; p++) n += sb_wr[p][o] - sb_rd[p][o];
        return n;
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic tbl_write(input int port, input int color, input logic [NP-1:0] m);
        cfg_we = 1'b1; cfg_port = 3'(port); cfg_color = CW'(color); cfg_mask = m;
        cyc();
        cfg_we = 1'b0;
    endtask

    // Scoreboard: expected copies per (input, output) pair, from a bench copy of the table.
    always @(negedge clk) begin
        int s;
        logic [NP-1:0] m;
        if (rst_n) begin
            for (int o = 0; o < NP; o++) begin
                if (tx_valid[o] && tx_ready[o]) begin
                    s = int'(tx_data[o][DW-1:DW-3]);
                    if (s >= NP || sb_rd[s][o] == sb_wr[s][o]) begin
                        chk(1'b0, "R2", "word on output with no expected copy", tx_data[o], o);
                    end else begin
                        chk({tx_color[o], tx_data[o]} == sb[s][o][sb_rd[s][o] % SBD], "R11",
                            "next word of input/output pair",
                            {tx_color[o], tx_data[o]}, sb[s][o][sb_rd[s][o] % SBD]);
                        sb_rd[s][o]++;
                    end
                    if (o == 4 && log_on && log_n < 32) begin
                        log_src[log_n] = s;
                        log_n++;
                    end
                end
            end
            for (int p = 0; p < NP; p++) begin
                if (rx_valid[p] && rx_ready[p]) begin
                    m = mtab[p][rx_color[p]];
                    for (int o = 0; o < NP; o++) begin
                        if (m[o]) begin
                            sb[p][o][sb_wr[p][o] % SBD] = {rx_color[p], rx_data[p]};
                            sb_wr[p][o]++;
                        end
                    end
                end
            end
            if (cfg_we && cfg_port < 3'(NP)) mtab[cfg_port][cfg_color] = cfg_mask;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R4 watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] w1, w2;
        void'($urandom(32'h1a2b3c4d));
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 8; c++) mtab[p][c] = '0;
            for (int o = 0; o < NP; o++) begin sb_wr[p][o] = 0; sb_rd[p][o] = 0; end
        end
        repeat (4) cyc();
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_valid == '0, "R1", "outputs idle after reset", tx_valid, 0);
        chk(rx_ready == 5'h1f, "R1", "inputs ready after reset", rx_ready, 5'h1f);

        // R1 / R9: empty table drops words and never blocks the input
        cyc();
        for (int i = 0; i < 6; i++) begin
            rx_valid[0] = 1'b1; rx_color[0] = 3'd0; rx_data[0] = mk_word(0);
            cyc();
            @(negedge clk);
            chk(rx_ready[0] == 1'b1, "R9", "empty-mask stream keeps input ready", rx_ready[0], 1);
            chk(tx_valid == '0, "R1", "no output from empty entry", tx_valid, 0);
        end
        rx_valid[0] = 1'b0;
        cyc();

        // R4: one-cycle hop, core -> east
        tbl_write(4, 1, 5'b00100);
        w1 = mk_word(4);
        rx_valid[4] = 1'b1; rx_color[4] = 3'd1; rx_data[4] = w1;
        cyc();
        rx_valid[4] = 1'b0;
        @(negedge clk);
        chk(tx_valid == 5'b00100, "R4", "east valid one cycle after intake", tx_valid, 5'b00100);
        chk(tx_data[2] == w1, "R4", "east data", tx_data[2], w1);
        chk(tx_color[2] == 3'd1, "R2", "color carried", tx_color[2], 1);
        cyc();

        // R8: write and arrival at the same edge use the old entry
        tbl_write(3, 2, 5'b00001);
        cfg_we = 1'b1; cfg_port = 3'd3; cfg_color = 3'd2; cfg_mask = 5'b00010;
        rx_valid[3] = 1'b1; rx_color[3] = 3'd2; rx_data[3] = mk_word(3);
        cyc();
        cfg_we = 1'b0;
        rx_data[3] = mk_word(3);
        @(negedge clk);
        chk(tx_valid == 5'b00001, "R8", "same-edge word uses old entry", tx_valid, 5'b00001);
        cyc();
        rx_valid[3] = 1'b0;
        @(negedge clk);
        chk(tx_valid == 5'b00010, "R8", "next word uses new entry", tx_valid, 5'b00010);
        cyc();
        // R8: out-of-range port write ignored
        tbl_write(7, 2, 5'b11111);
        rx_valid[3] = 1'b1; rx_color[3] = 3'd2; rx_data[3] = mk_word(3);
        cyc();
        rx_valid[3] = 1'b0;
        @(negedge clk);
        chk(tx_valid == 5'b00010, "R8", "port-7 write leaves entry alone", tx_valid, 5'b00010);
        cyc();

        // R3 / R5: multicast with one stalled output
        tx_ready = 5'b11110;
        tbl_write(1, 3, 5'b10101);
        w1 = mk_word(1);
        rx_valid[1] = 1'b1; rx_color[1] = 3'd3; rx_data[1] = w1;
        cyc();
        w2 = mk_word(1);
        rx_data[1] = w2;
        @(negedge clk);
        chk(tx_valid == 5'b10101, "R3", "multicast offered to all selected", tx_valid, 5'b10101);
        cyc();
        rx_valid[1] = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(tx_valid == 5'b00001, "R5", "only stalled output still valid", tx_valid, 5'b00001);
            chk(tx_data[0] == w1, "R5", "stalled output holds first word", tx_data[0], w1);
            cyc();
        end
        tx_ready = '1;
        @(negedge clk);
        cyc();
        @(negedge clk);
        chk(tx_valid == 5'b10101, "R3", "second multicast word offered", tx_valid, 5'b10101);
        chk(tx_data[4] == w2, "R11", "second word after first", tx_data[4], w2);
        cyc();

        // R6: queue fills to QDEPTH
        tx_ready = 5'b10111;
        tbl_write(0, 4, 5'b01000);
        for (int i = 0; i < QD; i++) begin
            rx_valid[0] = 1'b1; rx_color[0] = 3'd4; rx_data[0] = mk_word(0);
            cyc();
        end
        rx_valid[0] = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(rx_ready[0] == 1'b0, "R6", "full queue reports not ready", rx_ready[0], 0);
            cyc();
        end
        tx_ready = '1;
        repeat (QD + 2) cyc();
        @(negedge clk);
        chk(rx_ready[0] == 1'b1, "R6", "drained queue ready again", rx_ready[0], 1);
        chk(pending_to(3) == 0, "R6", "all queued words delivered", pending_to(3), 0);
        cyc();

        // R10: five disjoint flows in one cycle
        for (int p = 0; p < NP; p++) tbl_write(p, 5, 5'(1 << ((p + 1) % NP)));
        for (int p = 0; p < NP; p++) begin
            rx_valid[p] = 1'b1; rx_color[p] = 3'd5; rx_data[p] = mk_word(p);
        end
        cyc();
        rx_valid = '0;
        @(negedge clk);
        chk(tx_valid == 5'h1f, "R10", "all outputs busy together", tx_valid, 5'h1f);
        cyc();

        // R7: two sources contend for the core port
        tx_ready = 5'b01111;
        tbl_write(0, 6, 5'b10000);
        tbl_write(2, 6, 5'b10000);
        for (int i = 0; i < QD; i++) begin
            rx_valid[0] = 1'b1; rx_color[0] = 3'd6; rx_data[0] = mk_word(0);
            rx_valid[2] = 1'b1; rx_color[2] = 3'd6; rx_data[2] = mk_word(2);
            cyc();
        end
        rx_valid = '0;
        log_on = 1'b1; log_n = 0;
        tx_ready = '1;
        repeat (2 * QD + 2) cyc();
        log_on = 1'b0;
        chk(log_n == 2 * QD, "R7", "contended words delivered", log_n, 2 * QD);
        for (int i = 1; i < log_n; i++) begin
            chk(log_src[i] != log_src[i-1], "R7", "grants alternate", log_src[i], log_src[i-1]);
        end

        // Random traffic with table rewrites and random backpressure
        for (int c = 0; c < 3000; c++) begin
            cfg_we    = ($urandom % 8) == 0;
            cfg_port  = 3'($urandom % 8);
            cfg_color = CW'($urandom);
            cfg_mask  = NP'($urandom);
            for (int p = 0; p < NP; p++) begin
                rx_valid[p] = ($urandom % 3) != 0;
                rx_color[p] = CW'($urandom);
                rx_data[p]  = mk_word(p);
            end
            tx_ready = NP'($urandom | $urandom);
            cyc();
        end
        cfg_we = 1'b0; rx_valid = '0; tx_ready = '1;
        repeat (40) cyc();
        @(negedge clk);
        for (int o = 0; o < NP; o++) begin
            chk(pending_to(o) == 0, "R3", "every expected copy delivered", pending_to(o), 0);
        end
        chk(tx_valid == '0, "R2", "idle after drain", tx_valid, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule